// File: doc/BRIEF.md
# Bus Slave Address Match and Packet Check Front-End

This block sits behind the bit-level receiver of a power-management serial bus slave. It gets one-cycle strobes for each START (first or repeated) and each STOP, and a strobe with every byte seen on the bus. It decides whether the transaction is meant for this device. Three address classes are compared against every address byte at once: a programmable device address, two fixed global addresses, and an optional shared rail address used to write all phases of one rail together.

While a transaction is live, the block keeps a CRC-8 packet error code over every byte. At STOP it checks the code if the command layer says a PEC byte was appended. A packet timer starts at the first START and bounds the length of the transaction. If the timer runs out, the transfer is abandoned.

Results leave as registered strobes one clock after the event that caused them: address-hit strobes per class, forwarded data bytes, a PEC-good strobe, a timeout-abort strobe and a sticky communication-error flag. The controller has five states:

- IDLE waits for a START. First START: to ADDRESS.
- ADDRESS waits for the address byte. Matching byte: to SELECTED. Any other byte: to IGNORED.
- SELECTED forwards bytes.
- IGNORED drops bytes.
- ABORTED holds after a timeout.

From ADDRESS, SELECTED and IGNORED:
- STOP goes to IDLE.
- Timer expiry goes to ABORTED.
- Repeated START goes back to ADDRESS.

From ABORTED, only STOP leads out, to IDLE. The event priority is STOP, then timer expiry, then START, then byte.

Top module: `smb_addr_pec_front`

## Requirements
- R1: After reset all strobes, `addr_read` and `comm_err` are low, and bytes are ignored until a START.
- R2: An address byte whose bits [7:1] equal `dev_addr_reg[6:0]` while `dev_addr_reg[7]` is 0 pulses `hit_dev` one clock after the byte strobe. `addr_read` then holds the byte's bit 0 (1 = read).
- R3: With `dev_addr_reg[7]` set (for example 0x80), no address byte produces `hit_dev`.
- R4: Addresses 0x5A and 0x5B (bytes 0xB4/0xB5/0xB6/0xB7) pulse `hit_glob` for reads and writes, whatever `dev_addr_reg` holds.
- R5: An address byte matching `rail_addr_reg[6:0]`, with `rail_addr_reg[7]` 0, pulses `hit_rail` only when bit 0 is 0 (write). The same address with bit 0 = 1 is not selected.
- R6: After an address byte that matches no class, later bytes of that transaction produce no `rx_vld`.
- R7: In a selected transaction, each later byte appears on `rx_data` with a one-clock `rx_vld` pulse, one clock after its strobe.
- R8: The PEC is CRC-8 with polynomial x^8+x^2+x+1, initial value 0x00 and MSB first. It spans every byte from the first address byte, including the address byte after a repeated START. At STOP in a selected transaction with `pec_required` high, `pec_ok` pulses one clock later if the running code over all bytes, PEC byte included, is zero.
- R9: A PEC mismatch at STOP sets `comm_err`. It stays set until `err_clear` is pulsed, and it is low one clock after that pulse.
- R10: If no STOP arrives within `TIMEOUT_CYC` clocks of the first START, `timeout_abort` pulses and `comm_err` sets. Bytes are then ignored until STOP. A repeated START does not restart the timer.
- R11: A repeated START re-runs the address match on the following byte, and can select or deselect the transaction.
- R12: With `pec_required` low at STOP, neither `pec_ok` nor `comm_err` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START or repeated START strobe |
| ev_stop | input | 1 | STOP strobe |
| byte_vld | input | 1 | Byte-complete strobe |
| byte_data | input | 8 | Byte observed on the bus |
| dev_addr_reg | input | 8 | Device address, right-justified; bit 7 set disables it |
| rail_addr_reg | input | 8 | Shared rail address; bit 7 set disables it |
| pec_required | input | 1 | A PEC byte ends this transaction (sampled at STOP) |
| err_clear | input | 1 | Clears the sticky error flag |
| hit_dev | output | 1 | Device address matched |
| hit_glob | output | 1 | Global address matched |
| hit_rail | output | 1 | Rail address matched (write) |
| addr_read | output | 1 | Direction bit of the last address byte |
| rx_vld | output | 1 | Forwarded byte valid |
| rx_data | output | 8 | Forwarded byte |
| pec_ok | output | 1 | PEC good at STOP |
| timeout_abort | output | 1 | Packet timer expired |
| comm_err | output | 1 | Sticky PEC or timeout error |

## Verification
A wrong controller state shows up at the ports on the very next byte. A transaction left in IGNORED swallows a byte that should come out on `rx_vld`, and one left in SELECTED leaks a byte that should not. Either way the fault is visible one clock after the strobe.

A corrupted or mistimed code register never affects a byte output. It surfaces only at the STOP of a checked transaction, as a missing `pec_ok` or a spurious `comm_err`. The bench therefore ends each PEC case with a STOP and compares both outputs.

A timer that restarts on a repeated START shows only as a late abort. The bench places a repeated START shortly before expiry and checks that the abort arrives on the original schedule.

// File: rtl/smb_fe_pkg.sv
package smb_fe_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = BYTE_W - 1;
    localparam int NUM_GLB  = 2;
    localparam logic [BYTE_W-1:0] PEC_POLY = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SELECT,
        ST_IGNORE,
        ST_ABORT
    } fe_state_t;

    // One byte through the CRC-8 shift register, MSB first.
    function automatic logic [BYTE_W-1:0] pec_step(
        input logic [BYTE_W-1:0] acc,
        input logic [BYTE_W-1:0] din
    );
        logic [BYTE_W-1:0] r;
        r = acc ^ din;
        for (int b = 0; b < BYTE_W; b++) begin
            r = r[BYTE_W-1] ? ((r << 1) ^ PEC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_addr_match.sv
module smb_addr_match
    import smb_fe_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GLB_ADDR_A = 7'h5A,
    parameter logic [ADDR_W-1:0] GLB_ADDR_B = 7'h5B
) (
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [BYTE_W-1:0] dev_reg,
    input  logic [BYTE_W-1:0] rail_reg,
    output logic              dev_hit,
    output logic              glob_hit,
    output logic              rail_hit
);

    localparam logic [ADDR_W-1:0] GLB_TAB [NUM_GLB] = '{GLB_ADDR_A, GLB_ADDR_B};

    logic [ADDR_W-1:0]  addr7;
    logic               rw_bit;
    logic [NUM_GLB-1:0] glb_eq;

    assign addr7  = addr_byte[BYTE_W-1:1];
    assign rw_bit = addr_byte[0];

    for (genvar gi = 0; gi < NUM_GLB; gi++) begin : g_glb
        assign glb_eq[gi] = (addr7 == GLB_TAB[gi]);
    end

    assign glob_hit = |glb_eq;
    assign dev_hit  = !dev_reg[BYTE_W-1] && (addr7 == dev_reg[ADDR_W-1:0]);
    assign rail_hit = !rail_reg[BYTE_W-1] && (addr7 == rail_reg[ADDR_W-1:0]) && !rw_bit;

endmodule

// File: rtl/smb_crc8_acc.sv
module smb_crc8_acc
    import smb_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (upd) begin
            crc <= pec_step(crc, din);
        end
    end

endmodule

// File: rtl/smb_pkt_timer.sv
module smb_pkt_timer #(
    parameter int unsigned TIMEOUT_CYC = 8_750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/smb_addr_pec_front.sv
module smb_addr_pec_front
    import smb_fe_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 8_750_000,
    parameter logic [6:0]  GLB_ADDR_A  = 7'h5A,
    parameter logic [6:0]  GLB_ADDR_B  = 7'h5B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic [7:0] dev_addr_reg,
    input  logic [7:0] rail_addr_reg,
    input  logic       pec_required,
    input  logic       err_clear,
    output logic       hit_dev,
    output logic       hit_glob,
    output logic       hit_rail,
    output logic       addr_read,
    output logic       rx_vld,
    output logic [7:0] rx_data,
    output logic       pec_ok,
    output logic       timeout_abort,
    output logic       comm_err
);

    fe_state_t state, state_nx;

    logic       m_dev, m_glob, m_rail, m_any;
    logic       txn_live, first_start, tmo_fire, byte_take;
    logic       tmr_expired;
    logic [7:0] crc_q;
    logic       pec_bad;

    smb_addr_match #(
        .GLB_ADDR_A (GLB_ADDR_A),
        .GLB_ADDR_B (GLB_ADDR_B)
    ) i_match (
        .addr_byte (byte_data),
        .dev_reg   (dev_addr_reg),
        .rail_reg  (rail_addr_reg),
        .dev_hit   (m_dev),
        .glob_hit  (m_glob),
        .rail_hit  (m_rail)
    );

    assign m_any       = m_dev | m_glob | m_rail;
    assign txn_live    = (state == ST_ADDR) || (state == ST_SELECT) || (state == ST_IGNORE);
    assign first_start = (state == ST_IDLE) && ev_start;
    assign tmo_fire    = tmr_expired && !ev_stop;
    assign byte_take   = byte_vld && !ev_stop && !ev_start && !tmo_fire;

    smb_pkt_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (first_start),
        .run     (txn_live),
        .expired (tmr_expired)
    );

    smb_crc8_acc i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (first_start),
        .upd   (txn_live && byte_take),
        .din   (byte_data),
        .crc   (crc_q)
    );

    assign pec_bad = (crc_q != 8'h00);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ev_start && !ev_stop) state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (ev_stop)        state_nx = ST_IDLE;
                else if (tmo_fire)  state_nx = ST_ABORT;
                else if (ev_start)  state_nx = ST_ADDR;
                else if (byte_take) state_nx = m_any ? ST_SELECT : ST_IGNORE;
            end
            ST_SELECT, ST_IGNORE: begin
                if (ev_stop)       state_nx = ST_IDLE;
                else if (tmo_fire) state_nx = ST_ABORT;
                else if (ev_start) state_nx = ST_ADDR;
            end
            ST_ABORT: begin
                if (ev_stop) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_dev       <= 1'b0;
            hit_glob      <= 1'b0;
            hit_rail      <= 1'b0;
            addr_read     <= 1'b0;
            rx_vld        <= 1'b0;
            rx_data       <= '0;
            pec_ok        <= 1'b0;
            timeout_abort <= 1'b0;
            comm_err      <= 1'b0;
        end else begin
            hit_dev       <= 1'b0;
            hit_glob      <= 1'b0;
            hit_rail      <= 1'b0;
            rx_vld        <= 1'b0;
            pec_ok        <= 1'b0;
            timeout_abort <= 1'b0;

            if (err_clear) comm_err <= 1'b0;

            if (state == ST_ADDR && byte_take) begin
                hit_dev   <= m_dev;
                hit_glob  <= m_glob;
                hit_rail  <= m_rail;
                addr_read <= byte_data[0];
            end

            if (state == ST_SELECT && byte_take) begin
                rx_vld  <= 1'b1;
                rx_data <= byte_data;
            end

            if (state == ST_SELECT && ev_stop && pec_required) begin
                pec_ok <= !pec_bad;
                if (pec_bad) comm_err <= 1'b1;
            end

            if (txn_live && tmo_fire) begin
                timeout_abort <= 1'b1;
                comm_err      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/smb_fe_checker.sv
module smb_fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_stop,
    input logic       byte_vld,
    input logic [7:0] dev_addr_reg,
    input logic       err_clear,
    input logic       hit_dev,
    input logic       hit_glob,
    input logic       hit_rail,
    input logic       addr_read,
    input logic       rx_vld,
    input logic       pec_ok,
    input logic       timeout_abort,
    input logic       comm_err
);

    p_hit_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dev || hit_glob || hit_rail) |-> $past(byte_vld));

    p_dev_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dev |-> !$past(dev_addr_reg[7]));

    p_rail_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rail |-> !addr_read);

    p_rx_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> $past(byte_vld));

    p_pec_at_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pec_ok |-> $past(ev_stop));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(comm_err) && !$past(err_clear)) |-> comm_err);

    p_abort_flags_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_abort |-> comm_err);

    p_strobes_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({(hit_dev || hit_glob || hit_rail), rx_vld, pec_ok, timeout_abort}));

endmodule

bind smb_addr_pec_front smb_fe_checker i_fe_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_stop       (ev_stop),
    .byte_vld      (byte_vld),
    .dev_addr_reg  (dev_addr_reg),
    .err_clear     (err_clear),
    .hit_dev       (hit_dev),
    .hit_glob      (hit_glob),
    .hit_rail      (hit_rail),
    .addr_read     (addr_read),
    .rx_vld        (rx_vld),
    .pec_ok        (pec_ok),
    .timeout_abort (timeout_abort),
    .comm_err      (comm_err)
);

// File: tb/test_smb_addr_pec_front.sv
`timescale 1ns/1ps
module test_smb_addr_pec_front;

    localparam int TMO = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [7:0] dev_addr_reg = 8'h4F, rail_addr_reg = 8'h80;
    logic       pec_required = 1'b0, err_clear = 1'b0;
    logic       hit_dev, hit_glob, hit_rail, addr_read, rx_vld, pec_ok, timeout_abort, comm_err;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int aborts = 0;

    always #2 clk = ~clk;

    smb_addr_pec_front #(.TIMEOUT_CYC(TMO)) i_smb_addr_pec_front (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .byte_vld(byte_vld), .byte_data(byte_data), .dev_addr_reg(dev_addr_reg),
        .rail_addr_reg(rail_addr_reg), .pec_required(pec_required), .err_clear(err_clear),
        .hit_dev(hit_dev), .hit_glob(hit_glob), .hit_rail(hit_rail), .addr_read(addr_read),
        .rx_vld(rx_vld), .rx_data(rx_data), .pec_ok(pec_ok), .timeout_abort(timeout_abort),
        .comm_err(comm_err)
    );

    always @(negedge clk) if (timeout_abort) aborts++;

    // {dev_reg, rail_reg, addr_byte, 5'b0, exp_dev, exp_glob, exp_rail}
    localparam logic [31:0] VEC [10] = '{
        32'h4F_80_9E_04,  // R2 write to device
        32'h4F_80_9F_04,  // R2 read from device
        32'h80_80_00_00,  // R3 disabled device register
        32'h80_80_B4_02,  // R4 global A, device disabled
        32'h4F_80_B7_02,  // R4 global B read
        32'h4F_30_60_01,  // R5 rail write
        32'h4F_30_61_00,  // R5 rail read not selected
        32'h30_30_60_05,  // R2 R5 device and rail both
        32'h4F_80_9C_00,  // R6 no match
        32'h4F_80_B5_02   // R4 global A read
    };

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic do_stop();
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        byte_data = b; byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] pec;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes after reset",
              {hit_dev, hit_glob, hit_rail, rx_vld, pec_ok, timeout_abort}, 0);
        check("R1 comm_err after reset", comm_err, 0);
        do_byte(8'h9E);
        check("R1 byte before START ignored", {hit_dev, rx_vld}, 0);

        // Table walk over the address classes
        for (int v = 0; v < 10; v++) begin
            dev_addr_reg  = VEC[v][31:24];
            rail_addr_reg = VEC[v][23:16];
            pec_required  = 1'b0;
            do_start();
            do_byte(VEC[v][15:8]);
            check($sformatf("R2 R3 R4 R5 hits vec %0d", v),
                  {hit_dev, hit_glob, hit_rail}, VEC[v][2:0]);
            if (VEC[v][2:0] != 0)
                check($sformatf("R2 addr_read vec %0d", v), addr_read, VEC[v][8]);
            do_byte(8'hA5);
            check($sformatf("R6 R7 rx_vld vec %0d", v), rx_vld, (VEC[v][2:0] != 0));
            if (VEC[v][2:0] != 0) check($sformatf("R7 rx_data vec %0d", v), rx_data, 8'hA5);
            do_stop();
            check($sformatf("R12 no pec result vec %0d", v), {pec_ok, comm_err}, 0);
        end

        // R8 good PEC, write with three bytes
        dev_addr_reg = 8'h4F; rail_addr_reg = 8'h80;
        pec = crc_byte(crc_byte(crc_byte(8'h00, 8'h9E), 8'h21), 8'h34);
        do_start(); do_byte(8'h9E); do_byte(8'h21); do_byte(8'h34); do_byte(pec);
        check("R7 PEC byte forwarded", {rx_vld, rx_data}, {1'b1, pec});
        pec_required = 1'b1;
        do_stop();
        check("R8 pec_ok good write", pec_ok, 1);
        check("R8 no error on good PEC", comm_err, 0);

        // R8 R11 repeated START: code spans both address bytes
        pec = crc_byte(crc_byte(crc_byte(crc_byte(8'h00, 8'h9E), 8'h8B), 8'h9F), 8'h5C);
        do_start(); do_byte(8'h9E); do_byte(8'h8B);
        do_start(); do_byte(8'h9F);
        check("R11 reselect after Sr", {hit_dev, addr_read}, 2'b11);
        do_byte(8'h5C); do_byte(pec);
        do_stop();
        check("R8 pec_ok across Sr", pec_ok, 1);

        // R9 bad PEC sets sticky error
        do_start(); do_byte(8'h9E); do_byte(8'h21); do_byte(8'h00);
        do_stop();
        check("R9 bad PEC no pec_ok", pec_ok, 0);
        check("R9 bad PEC sets comm_err", comm_err, 1);
        pec_required = 1'b0;
        do_start(); do_byte(8'hB4); do_byte(8'h11); do_stop();
        check("R9 comm_err sticky", comm_err, 1);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        check("R9 comm_err cleared", comm_err, 0);

        // R11 R5 Sr to rail address as read deselects
        rail_addr_reg = 8'h30;
        do_start(); do_byte(8'h60);
        check("R5 rail write selected", hit_rail, 1);
        do_byte(8'h01);
        do_start(); do_byte(8'h61);
        check("R11 rail read after Sr not selected", {hit_dev, hit_glob, hit_rail}, 0);
        do_byte(8'h77);
        check("R11 R6 bytes dropped after deselect", rx_vld, 0);
        do_stop();

        // R10 timeout, Sr does not restart the timer
        aborts = 0;
        do_start(); do_byte(8'h9E);
        idle(TMO - 60);
        do_start(); do_byte(8'h9E);
        idle(55);
        check("R10 no abort before limit", aborts, 0);
        idle(10);
        check("R10 abort on first-START schedule", aborts, 1);
        check("R10 timeout sets comm_err", comm_err, 1);
        do_byte(8'h42);
        check("R10 bytes ignored after abort", rx_vld, 0);
        do_start(); do_byte(8'h9E);
        check("R10 START ignored while aborted", hit_dev, 0);
        do_stop();
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        do_start(); do_byte(8'h9E);
        check("R10 recovers after STOP", hit_dev, 1);
        do_stop();
        check("R10 single abort", aborts, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule